// File: doc/BRIEF.md
# Flow Filter Table Command Engine

This block owns a bucketed table of flow-filter entries and executes host commands against it. The host first writes a hash word. The hash word carries a bucket-selecting key, an optional software index and a valid flag. The host then writes a command word that holds an opcode and the entry attributes. The engine latches the command, executes it against the bucket the key selects, and writes a result back into the readback copy of the command word. Software polls that readback until the opcode field reads zero.

Three opcodes exist: add, query and remove. A query and a remove report through a hit flag whether a matching entry is present, and return that entry's stored attributes. An add can insert a new entry, overwrite an existing entry when the update flag is set, or fail with one of three error flags. In perfect-match mode the software index is part of the key, and a drop request stores the configured drop queue in place of the requested queue. In signature mode a drop request is refused.

Top module: `flt_cmd_engine`

## Requirements
- R1: After reset the readback word is all zero and every bucket is empty, so a query of any key reports hit = 0.
- R2: A command write with a non-zero opcode (bits [1:0]: 1 add, 2 query, 3 remove) while idle makes the readback show that opcode on the next cycle, with bits 2 and 12:10 cleared. On the cycle after that the opcode reads zero and the result is present.
- R3: Command writes whose opcode is zero, and any hash or command write made while a command is busy, have no effect. While idle with no accepted command, the readback does not change.
- R4: When the hash word and the command word are written in the same cycle, the command runs on that new hash word.
- R5: An add whose key is absent, in a bucket with a free slot, stores the entry and reports hit (bit 2). A later query of the same key returns hit and the stored queue-enable (bit 5), flow type [9:7], queue [22:16] and pool [29:24].
- R6: An add is refused with the bad-request flag (bit 12) and leaves the table unchanged when the hash valid bit (bit 31) is clear, or when the drop flag (bit 6) is set in signature mode.
- R7: In perfect-match mode an add with the drop flag set stores the drop-queue input as the entry's queue.
- R8: An add to an existing key with the update flag (bit 3) set overwrites the entry's attributes. Without the update flag, the add reports the duplicate flag (bit 10) and hit, and the entry is left unchanged.
- R9: Each bucket (selected by hash bits [BKT_W-1:0]) holds DEPTH entries. An add of a new key to a full bucket reports the overflow flag (bit 11) with hit clear.
- R10: A remove of a present key reports hit with the entry's attributes and frees the slot. A remove of an absent key reports hit clear and changes nothing.
- R11: The key is hash bits [15:0]. In perfect-match mode the software index in hash bits [30:16] also takes part in the match. In signature mode the software index is ignored.
- R12: At most one of the three error flags is set in any readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hashWr | input | 1 | Hash word write strobe |
| hashData | input | 32 | Hash word: valid [31], software index [30:16], key [15:0] |
| cmdWr | input | 1 | Command word write strobe |
| cmdData | input | 32 | Command word: opcode and attributes |
| perfectMode | input | 1 | 1 selects perfect-match mode, 0 selects signature mode |
| dropQueue | input | 7 | Queue stored for drop requests in perfect-match mode |
| statusOut | output | 32 | Readback of the command word: busy opcode or result |

## Verification
A hash write and a command write can land in the same cycle. A second command can also arrive in the very cycle that the first one executes its table update. The bench provokes both cases. It writes a stale hash word first and then a new hash word together with a query, and it fires a second add while the first is still busy. A reference model kept as per-bucket queues judges each cycle's readback, and follow-up queries show whether the ignored add left any trace in the table.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int QUEUE_W = 7;
  localparam int POOL_W  = 6;
  localparam int FT_W    = 3;
  localparam int KEY_W   = 16;
  localparam int IDX_W   = 15;

  // command / readback word bit positions
  localparam int HIT_B   = 2;
  localparam int UPD_B   = 3;
  localparam int LAST_B  = 4;
  localparam int QEN_B   = 5;
  localparam int DROP_B  = 6;
  localparam int FT_LO   = 7;
  localparam int DUP_B   = 10;
  localparam int FULL_B  = 11;
  localparam int BAD_B   = 12;
  localparam int Q_LO    = 16;
  localparam int POOL_LO = 24;
  // hash word bit positions
  localparam int IDX_LO  = 16;
  localparam int HVLD_B  = 31;

  // fields echoed while busy (opcode, flags, attributes)
  localparam logic [31:0] ECHO_MASK = 32'h3F7F_03FB;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_ADD    = 2'd1,
    OP_QUERY  = 2'd2,
    OP_REMOVE = 2'd3
  } op_e;

  typedef struct packed {
    logic latchHash;
    logic latchCmd;
    logic exec;
  } strobe_t;

  typedef struct packed {
    logic              qEn;
    logic [FT_W-1:0]   flowType;
    logic [QUEUE_W-1:0] queue;
    logic [POOL_W-1:0] pool;
  } attr_t;
endpackage

// File: rtl/fce_ctrl.sv
module fce_ctrl
  import fce_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hashWr,
  input  logic       cmdWr,
  input  logic [1:0] cmdOp,
  output strobe_t    strobes
);
  logic busyQ;

  always_comb begin
    strobes.latchHash = hashWr && !busyQ;
    strobes.latchCmd  = cmdWr && !busyQ && (cmdOp != OP_IDLE);
    strobes.exec      = busyQ;
  end

  // one busy cycle per accepted command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyQ <= 1'b0;
    else       busyQ <= strobes.latchCmd;
  end
endmodule

// File: rtl/fce_datapath.sv
module fce_datapath
  import fce_pkg::*;
#(
  parameter int BKT_W = 3,
  parameter int DEPTH = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [31:0]        hashData,
  input  logic [31:0]        cmdData,
  input  logic               perfectMode,
  input  logic [QUEUE_W-1:0] dropQueue,
  output logic [31:0]        statusOut
);
  localparam int NB     = 1 << BKT_W;
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0] hashQ, cmdQ, statQ;

  logic              entValid [NB][DEPTH];
  logic [KEY_W-1:0]  entKey   [NB][DEPTH];
  logic [IDX_W-1:0]  entIdx   [NB][DEPTH];
  attr_t             entAttr  [NB][DEPTH];

  logic [BKT_W-1:0]  bkt;
  logic [KEY_W-1:0]  keyIn;
  logic [IDX_W-1:0]  idxIn;
  logic [DEPTH-1:0]  hitVec, freeVec;
  logic              anyHit, anyFree;
  logic [SLOT_W-1:0] hitSlot, freeSlot;
  attr_t             newAttr, hitAttr;
  logic              wrEn, clrEn;
  logic [SLOT_W-1:0] wrSlot;
  logic [31:0]       result;

  assign bkt   = hashQ[BKT_W-1:0];
  assign keyIn = hashQ[KEY_W-1:0];
  assign idxIn = hashQ[IDX_LO +: IDX_W];

  // per-slot comparators of the addressed bucket
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    assign hitVec[s]  = entValid[bkt][s] && (entKey[bkt][s] == keyIn) &&
                        (!perfectMode || (entIdx[bkt][s] == idxIn));
    assign freeVec[s] = !entValid[bkt][s];
  end

  // lowest-index selection
  always_comb begin
    anyHit   = 1'b0;
    anyFree  = 1'b0;
    hitSlot  = '0;
    freeSlot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hitVec[i])  begin anyHit  = 1'b1; hitSlot  = SLOT_W'(i); end
      if (freeVec[i]) begin anyFree = 1'b1; freeSlot = SLOT_W'(i); end
    end
  end

  function automatic logic [31:0] putAttr(input logic [31:0] w, input attr_t a);
    logic [31:0] r;
    r = w;
    r[QEN_B]             = a.qEn;
    r[FT_LO +: FT_W]     = a.flowType;
    r[Q_LO +: QUEUE_W]   = a.queue;
    r[POOL_LO +: POOL_W] = a.pool;
    return r;
  endfunction

  always_comb begin
    newAttr.qEn      = cmdQ[QEN_B];
    newAttr.flowType = cmdQ[FT_LO +: FT_W];
    newAttr.pool     = cmdQ[POOL_LO +: POOL_W];
    newAttr.queue    = (cmdQ[DROP_B] && perfectMode) ? dropQueue : cmdQ[Q_LO +: QUEUE_W];
    hitAttr          = entAttr[bkt][hitSlot];
  end

  // command decode and result formation
  always_comb begin
    wrEn   = 1'b0;
    clrEn  = 1'b0;
    wrSlot = freeSlot;
    result = cmdQ & ECHO_MASK;
    result[1:0] = OP_IDLE;
    case (op_e'(cmdQ[1:0]))
      OP_ADD: begin
        if (!hashQ[HVLD_B] || (cmdQ[DROP_B] && !perfectMode)) begin
          result[BAD_B] = 1'b1;
        end else if (anyHit) begin
          result[HIT_B] = 1'b1;
          if (cmdQ[UPD_B]) begin
            wrEn   = 1'b1;
            wrSlot = hitSlot;
            result = putAttr(result, newAttr);
          end else begin
            result[DUP_B] = 1'b1;
          end
        end else if (anyFree) begin
          wrEn          = 1'b1;
          result[HIT_B] = 1'b1;
          result        = putAttr(result, newAttr);
        end else begin
          result[FULL_B] = 1'b1;
        end
      end
      OP_QUERY: begin
        if (anyHit) begin
          result[HIT_B] = 1'b1;
          result        = putAttr(result, hitAttr);
        end
      end
      OP_REMOVE: begin
        if (anyHit) begin
          clrEn         = 1'b1;
          result[HIT_B] = 1'b1;
          result        = putAttr(result, hitAttr);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hashQ <= '0;
      cmdQ  <= '0;
      statQ <= '0;
    end else begin
      if (strobes.latchHash) hashQ <= hashData;
      if (strobes.latchCmd) begin
        cmdQ  <= cmdData;
        statQ <= cmdData & ECHO_MASK;
      end else if (strobes.exec) begin
        statQ <= result;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NB; b++)
        for (int s = 0; s < DEPTH; s++)
          entValid[b][s] <= 1'b0;
    end else if (strobes.exec) begin
      if (wrEn)  entValid[bkt][wrSlot]  <= 1'b1;
      if (clrEn) entValid[bkt][hitSlot] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.exec && wrEn) begin
      entKey[bkt][wrSlot]  <= keyIn;
      entIdx[bkt][wrSlot]  <= idxIn;
      entAttr[bkt][wrSlot] <= newAttr;
    end
  end

  assign statusOut = statQ;
endmodule

// File: rtl/flt_cmd_engine.sv
module flt_cmd_engine
  import fce_pkg::*;
#(
  parameter int BKT_W = 3,
  parameter int DEPTH = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hashWr,
  input  logic [31:0]        hashData,
  input  logic               cmdWr,
  input  logic [31:0]        cmdData,
  input  logic               perfectMode,
  input  logic [QUEUE_W-1:0] dropQueue,
  output logic [31:0]        statusOut
);
  strobe_t strobes;

  fce_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hashWr  (hashWr),
    .cmdWr   (cmdWr),
    .cmdOp   (cmdData[1:0]),
    .strobes (strobes)
  );

  fce_datapath #(.BKT_W(BKT_W), .DEPTH(DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .hashData    (hashData),
    .cmdData     (cmdData),
    .perfectMode (perfectMode),
    .dropQueue   (dropQueue),
    .statusOut   (statusOut)
  );
endmodule

// File: rtl/fce_chk.sv
module fce_chk
  import fce_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               hashWr,
  input logic [31:0]        hashData,
  input logic               cmdWr,
  input logic [31:0]        cmdData,
  input logic               perfectMode,
  input logic [QUEUE_W-1:0] dropQueue,
  input logic [31:0]        statusOut
);
  logic idle;
  assign idle = (statusOut[1:0] == OP_IDLE);

  assert_busy_echo_R2: assert property (@(posedge clk) disable iff (!rstN)
    (idle && cmdWr && cmdData[1:0] != OP_IDLE) |=> (statusOut[1:0] == $past(cmdData[1:0])));

  assert_single_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    !idle |=> idle);

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !(cmdWr && cmdData[1:0] != OP_IDLE)) |=> $stable(statusOut));

  assert_sig_drop_refused_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[1:0] == OP_ADD && statusOut[DROP_B] && !perfectMode) |=> statusOut[BAD_B]);

  assert_full_no_hit_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[FULL_B] |-> !statusOut[HIT_B]);

  assert_one_error_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(statusOut[BAD_B:DUP_B]));
endmodule

bind flt_cmd_engine fce_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hashWr      (hashWr),
  .hashData    (hashData),
  .cmdWr       (cmdWr),
  .cmdData     (cmdData),
  .perfectMode (perfectMode),
  .dropQueue   (dropQueue),
  .statusOut   (statusOut)
);

// File: tb/sim_flt_cmd_engine.sv
module sim_flt_cmd_engine;
  localparam int DEPTH = 10;
  localparam logic [31:0] ATTR_MASK = 32'h3F7F_03A0;
  localparam logic [31:0] RES_MASK  = 32'h3F7F_03F8;

  logic        clk = 0;
  logic        rstN = 0;
  logic        hashWr = 0, cmdWr = 0, perfectMode = 0;
  logic [31:0] hashData = 0, cmdData = 0;
  logic [6:0]  dropQueue = 0;
  logic [31:0] statusOut;

  int errors = 0, nChecks = 0, cyc = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  flt_cmd_engine u0 (
    .clk(clk), .rstN(rstN), .hashWr(hashWr), .hashData(hashData),
    .cmdWr(cmdWr), .cmdData(cmdData), .perfectMode(perfectMode),
    .dropQueue(dropQueue), .statusOut(statusOut)
  );

  // ---------------- reference model ----------------
  typedef struct { logic [15:0] key; logic [14:0] idx; logic [31:0] attr; } ent_t;
  ent_t        tbl [8][$];
  logic [31:0] mHash, mCmd, mStat;
  bit          mBusy;

  task automatic modelExec();
    int b, hitPos;
    logic [31:0] res, na;
    logic drop;
    ent_t e;
    b = int'(mHash[2:0]);
    res = mCmd & RES_MASK;
    drop = mCmd[6];
    hitPos = -1;
    foreach (tbl[b][j])
      if (tbl[b][j].key == mHash[15:0] && (!perfectMode || tbl[b][j].idx == mHash[30:16]))
        hitPos = j;
    na = mCmd & ATTR_MASK;
    if (drop && perfectMode) na[22:16] = dropQueue;
    case (mCmd[1:0])
      2'd1: begin
        if (!mHash[31] || (drop && !perfectMode)) res[12] = 1;
        else if (hitPos >= 0) begin
          res[2] = 1;
          if (mCmd[3]) begin tbl[b][hitPos].attr = na; res = (res & ~ATTR_MASK) | na; end
          else res[10] = 1;
        end else if (tbl[b].size() < DEPTH) begin
          e.key = mHash[15:0]; e.idx = mHash[30:16]; e.attr = na;
          tbl[b].push_back(e);
          res[2] = 1; res = (res & ~ATTR_MASK) | na;
        end else res[11] = 1;
      end
      2'd2: if (hitPos >= 0) begin res[2] = 1; res = (res & ~ATTR_MASK) | tbl[b][hitPos].attr; end
      2'd3: if (hitPos >= 0) begin
        res[2] = 1; res = (res & ~ATTR_MASK) | tbl[b][hitPos].attr;
        tbl[b].delete(hitPos);
      end
      default: ;
    endcase
    mStat = res;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mHash = 0; mCmd = 0; mStat = 0; mBusy = 0;
      for (int b = 0; b < 8; b++) tbl[b].delete();
    end else if (mBusy) begin
      modelExec();
      mBusy = 0;
    end else begin
      if (hashWr) mHash = hashData;
      if (cmdWr && cmdData[1:0] != 0) begin
        mCmd = cmdData; mStat = cmdData & 32'h3F7F_03FB; mBusy = 1;
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      nChecks++;
      if (statusOut !== mStat) begin
        errors++;
        $display("FAIL %s cycle %0d statusOut=%h expected=%h", curReq, cyc, statusOut, mStat);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; nChecks++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, nChecks);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] mk(input logic [1:0] op, input bit upd, input bit drop,
                                     input logic [2:0] ft, input logic [6:0] q,
                                     input logic [5:0] pool, input bit qen);
    logic [31:0] w = 0;
    w[1:0] = op; w[3] = upd; w[4] = 1; w[5] = qen; w[6] = drop;
    w[9:7] = ft; w[22:16] = q; w[29:24] = pool;
    return w;
  endfunction

  function automatic logic [31:0] hk(input bit vld, input logic [14:0] idx, input logic [15:0] key);
    return {vld, idx, key};
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] h, input logic [31:0] c);
    @(negedge clk);
    hashWr = 1; hashData = h; cmdWr = 1; cmdData = c;
    @(negedge clk);
    hashWr = 0; cmdWr = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", int'(statusOut), 0);
    rstN = 1;
    @(negedge clk);

    curReq = "R1";
    issue(hk(1, 0, 16'h0012), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R1", int'(statusOut[2]), 0);

    curReq = "R5";
    issue(hk(1, 0, 16'h0012), mk(1, 0, 0, 3'd2, 7'd5, 6'd3, 1));
    chk("R5", int'(statusOut[2]), 1);
    issue(hk(1, 0, 16'h0012), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R5", int'(statusOut[22:16]), 5);
    chk("R5", int'(statusOut[29:24]), 3);
    chk("R5", int'(statusOut[9:7]), 2);

    curReq = "R8";
    issue(hk(1, 0, 16'h0012), mk(1, 0, 0, 3'd1, 7'd9, 6'd1, 1));
    chk("R8", int'(statusOut[10]), 1);
    issue(hk(1, 0, 16'h0012), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R8", int'(statusOut[22:16]), 5);
    issue(hk(1, 0, 16'h0012), mk(1, 1, 0, 3'd1, 7'd9, 6'd1, 1));
    issue(hk(1, 0, 16'h0012), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R8", int'(statusOut[22:16]), 9);

    curReq = "R6";
    issue(hk(0, 0, 16'h0022), mk(1, 0, 0, 3'd1, 7'd4, 6'd1, 1));
    chk("R6", int'(statusOut[12]), 1);
    issue(hk(1, 0, 16'h0022), mk(1, 0, 1, 3'd1, 7'd4, 6'd1, 1));
    chk("R6", int'(statusOut[12]), 1);
    issue(hk(1, 0, 16'h0022), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R6", int'(statusOut[2]), 0);

    curReq = "R9";
    for (int n = 0; n < DEPTH; n++)
      issue(hk(1, 0, 16'h0003 | 16'(n << 3)), mk(1, 0, 0, 3'd0, 7'(n), 6'd0, 1));
    issue(hk(1, 0, 16'h0003 | 16'(10 << 3)), mk(1, 0, 0, 3'd0, 7'd10, 6'd0, 1));
    chk("R9", int'(statusOut[11]), 1);
    chk("R9", int'(statusOut[2]), 0);

    curReq = "R10";
    issue(hk(1, 0, 16'h0003 | 16'(4 << 3)), mk(3, 0, 0, 0, 0, 0, 0));
    chk("R10", int'(statusOut[2]), 1);
    chk("R10", int'(statusOut[22:16]), 4);
    issue(hk(1, 0, 16'h0003 | 16'(4 << 3)), mk(3, 0, 0, 0, 0, 0, 0));
    chk("R10", int'(statusOut[2]), 0);
    issue(hk(1, 0, 16'h0003 | 16'(10 << 3)), mk(1, 0, 0, 3'd0, 7'd10, 6'd0, 1));
    chk("R10", int'(statusOut[2]), 1);

    curReq = "R3";
    @(negedge clk); cmdWr = 1; cmdData = 32'h0000_0050;
    @(negedge clk); cmdWr = 0;
    chk("R3", int'(statusOut[1:0]), 0);
    @(negedge clk);
    hashWr = 1; hashData = hk(1, 0, 16'h0044); cmdWr = 1; cmdData = mk(2, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    hashData = hk(1, 0, 16'h0054); cmdData = mk(1, 0, 0, 3'd1, 7'd7, 6'd2, 1);
    @(negedge clk);
    hashWr = 0; cmdWr = 0;
    @(negedge clk);
    issue(hk(1, 0, 16'h0054), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R3", int'(statusOut[2]), 0);

    curReq = "R4";
    @(negedge clk); hashWr = 1; hashData = hk(1, 0, 16'h0066);
    @(negedge clk); hashWr = 0;
    issue(hk(1, 0, 16'h0012), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R4", int'(statusOut[2]), 1);

    curReq = "R11";
    issue(hk(1, 15'd7, 16'h0012), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R11", int'(statusOut[2]), 1);
    perfectMode = 1;
    issue(hk(1, 15'd1, 16'h0105), mk(1, 0, 0, 3'd3, 7'd11, 6'd4, 1));
    issue(hk(1, 15'd2, 16'h0105), mk(1, 0, 0, 3'd3, 7'd12, 6'd4, 1));
    chk("R11", int'(statusOut[10]), 0);
    issue(hk(1, 15'd3, 16'h0105), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R11", int'(statusOut[2]), 0);
    issue(hk(1, 15'd2, 16'h0105), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R11", int'(statusOut[22:16]), 12);

    curReq = "R7";
    dropQueue = 7'h55;
    issue(hk(1, 15'd0, 16'h0205), mk(1, 0, 1, 3'd1, 7'd3, 6'd1, 1));
    issue(hk(1, 15'd0, 16'h0205), mk(2, 0, 0, 0, 0, 0, 0));
    chk("R7", int'(statusOut[22:16]), 'h55);

    curReq = "R12";
    issue(hk(1, 15'd0, 16'h0205), mk(1, 0, 0, 3'd1, 7'd3, 6'd1, 1));
    chk("R12", int'(statusOut[12:10]), 1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, nChecks);
    $finish;
  end
endmodule